// File: doc/BRIEF.md
# Fractional Oversampling Baud Tick Generator

This block turns a free-running system clock into two single-cycle strobes for a serial port: a sample tick at the oversampling rate and a bit tick that marks each bit period. The sample-tick period comes from a programmable divisor. In integer style a divisor value N gives N+1 clocks per sample tick. In fractional style the period averages (mantissa + fraction/16) clocks. A four-bit phase accumulator decides which tick periods are stretched by one clock, and it spreads those long periods evenly, so over any sixteen consecutive tick periods the total is exact.

A two-bit ratio select sets how many sample ticks make one bit: 8, 16, 32 or 64. The bit tick is raised together with every such sample tick. The divisor, fraction, style and ratio are captured into shadow registers only while the block is disabled or at a bit-tick boundary, so a bit period that is in progress always finishes with the settings it started with. The receiver or transmitter that uses the strobes just counts them. Each strobe comes straight from a flip-flop.

Top module: `uart_frac_brg`

## Requirements
- R1: With `frac_style`=0 (integer style), every interval between sample ticks is exactly `div_mant`+1 clocks, and `div_frac` has no effect.
- R2: With `frac_style`=1, every sample-tick interval is M or M+1 clocks, where M is `div_mant`. Any 16 consecutive intervals total exactly 16·M + `div_frac` clocks. The first n·R intervals after enable total n·R·M + floor(n·R·`div_frac`/16) clocks.
- R3: With `frac_style`=1, a `div_mant` of 0 is treated as 1, so each interval is 1 or 2 clocks.
- R4: `os_sel` encoding: 2'b00 gives 16 sample ticks per bit, 2'b01 gives 8, 2'b10 gives 32 and 2'b11 gives 64. `bit_tick` is high only in a cycle in which `sample_tick` is high, and the k-th bit tick coincides with sample tick k·R.
- R5: With integer style, `div_mant`=103 and `os_sel`=2'b00, bit ticks fall at 1664 and 3328 clocks after enable.
- R6: A change of divisor, fraction, style or ratio while enabled has no effect on the bit period in progress. It applies from the first sample period after the next bit tick.
- R7: While `en` is low, both outputs stay low and all counters and the accumulator are cleared. The first sample tick is seen P clock edges after the first edge that samples `en` high, where P is the first programmed interval.
- R8: While `rst` is high, both outputs are low, including when `en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears and holds all counting state |
| frac_style | input | 1 | 0: integer divisor (N+1 clocks); 1: mantissa plus sixteenths |
| div_mant | input | MANT_W | Divisor integer part |
| div_frac | input | 4 | Divisor fraction in sixteenths (fractional style only) |
| os_sel | input | 2 | Sample ticks per bit: 00=16, 01=8, 10=32, 11=64 |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit strobe, coincident with a sample tick |

## Verification
A wrong count or accumulator value shows up at the sample-tick output during the first tick period it touches. It appears as an interval outside {M, M+1}, or as a sixteen-interval total that is off by a clock, within at most sixteen ticks. A wrong ratio counter or a shadow register that loads at the wrong time shifts the bit tick against the sample-tick count, or moves the bit-tick time, within the first two bit periods. The sweep covers every ratio with small divisors and all fraction corners, so each fault is reached within a few hundred clocks of enable.

// File: rtl/brg_pkg.sv
package brg_pkg;

  typedef enum logic [1:0] {
    OS_X16 = 2'b00,
    OS_X8  = 2'b01,
    OS_X32 = 2'b10,
    OS_X64 = 2'b11
  } os_mode_e;

  localparam int OS_CNT_W  = 6;
  localparam int FRAC_W    = 4;

  function automatic logic [OS_CNT_W:0] os_ratio(input os_mode_e m);
    case (m)
      OS_X8:   os_ratio = 7'd8;
      OS_X32:  os_ratio = 7'd32;
      OS_X64:  os_ratio = 7'd64;
      default: os_ratio = 7'd16;
    endcase
  endfunction

endpackage

// File: rtl/brg_cfg_shadow.sv
module brg_cfg_shadow
  import brg_pkg::*;
#(
  parameter int MW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              style_i,
  input  logic [MW-1:0]     mant_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  os_mode_e          mode_i,
  output logic [MW:0]       base_o,
  output logic [FRAC_W-1:0] frac_o,
  output os_mode_e          mode_o
);

  logic              style_q;
  logic [MW-1:0]     mant_q;
  logic [FRAC_W-1:0] frac_q;
  os_mode_e          mode_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      style_q <= style_i;
      mant_q  <= mant_i;
      frac_q  <= frac_i;
      mode_q  <= mode_i;
    end
  end

  // integer style: N+1 clocks; fractional style: mantissa, zero read as one
  always_comb begin
    if (!style_q) begin
      base_o = {1'b0, mant_q} + {{MW{1'b0}}, 1'b1};
      frac_o = '0;
    end else begin
      base_o = (mant_q == '0) ? {{MW{1'b0}}, 1'b1} : {1'b0, mant_q};
      frac_o = frac_q;
    end
  end
  assign mode_o = mode_q;

  // R6: settings move only on a load
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(mant_q) && $stable(frac_q) && $stable(style_q) && $stable(mode_q)));

endmodule

// File: rtl/brg_tick_period.sv
module brg_tick_period
  import brg_pkg::*;
#(
  parameter int MW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [MW:0]       base_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              period_end_o,
  output logic              s_tick_o
);

  logic [MW:0]       cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic              carry;
  logic [MW:0]       end_val;

  assign sum          = {1'b0, acc} + {1'b0, frac_i};
  assign carry        = sum[FRAC_W];
  assign end_val      = base_i + {{MW{1'b0}}, carry} - {{MW{1'b0}}, 1'b1};
  assign period_end_o = en && (cnt == end_val);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt      <= '0;
      acc      <= '0;
      s_tick_o <= 1'b0;
    end else begin
      s_tick_o <= period_end_o;
      if (period_end_o) begin
        cnt <= '0;
        acc <= sum[FRAC_W-1:0];
      end else begin
        cnt <= cnt + {{MW{1'b0}}, 1'b1};
      end
    end
  end

  // R2: count never runs past the stretched end
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= end_val);

  // R2: phase only advances at a period end
  assert_acc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !period_end_o) |=> $stable(acc));

  // R7: disabled means cleared and silent
  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!s_tick_o && cnt == '0 && acc == '0));

endmodule

// File: rtl/brg_bit_divider.sv
module brg_bit_divider
  import brg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  os_mode_e mode_i,
  input  logic     period_end_i,
  output logic     bit_fire_o,
  output logic     b_tick_o
);

  logic [OS_CNT_W-1:0] oscnt;
  logic [OS_CNT_W:0]   ratio;
  logic                last_os;

  assign ratio      = os_ratio(mode_i);
  assign last_os    = ({1'b0, oscnt} == (ratio - 7'd1));
  assign bit_fire_o = period_end_i && last_os;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      oscnt    <= '0;
      b_tick_o <= 1'b0;
    end else begin
      b_tick_o <= bit_fire_o;
      if (period_end_i)
        oscnt <= last_os ? '0 : oscnt + 1'b1;
    end
  end

  // R4: tick count stays inside the selected ratio
  assert_oscnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    {1'b0, oscnt} < ratio);

  // R7
  assert_bit_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!b_tick_o && oscnt == '0));

endmodule

// File: rtl/uart_frac_brg.sv
module uart_frac_brg
  import brg_pkg::*;
#(
  parameter int MANT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              frac_style,
  input  logic [MANT_W-1:0] div_mant,
  input  logic [3:0]        div_frac,
  input  logic [1:0]        os_sel,
  output logic              sample_tick,
  output logic              bit_tick
);

  logic [MANT_W:0]   base;
  logic [FRAC_W-1:0] frac_eff;
  os_mode_e          mode_sh;
  logic              period_end;
  logic              bit_fire;
  logic              load;

  assign load = !en || bit_fire;

  brg_cfg_shadow #(.MW(MANT_W)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .style_i (frac_style),
    .mant_i  (div_mant),
    .frac_i  (div_frac),
    .mode_i  (os_mode_e'(os_sel)),
    .base_o  (base),
    .frac_o  (frac_eff),
    .mode_o  (mode_sh)
  );

  brg_tick_period #(.MW(MANT_W)) u_period (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .base_i       (base),
    .frac_i       (frac_eff),
    .period_end_o (period_end),
    .s_tick_o     (sample_tick)
  );

  brg_bit_divider u_bitdiv (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .mode_i       (mode_sh),
    .period_end_i (period_end),
    .bit_fire_o   (bit_fire),
    .b_tick_o     (bit_tick)
  );

  // R4: a bit tick always rides on a sample tick
  assert_bit_on_sample_R4: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick);

  // R8: reset silences both strobes
  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (!sample_tick && !bit_tick));

endmodule

// File: tb/uart_frac_brg_bench.sv
module uart_frac_brg_bench;

  localparam int MW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          frac_style = 1'b0;
  logic [MW-1:0] div_mant = '0;
  logic [3:0]    div_frac = '0;
  logic [1:0]    os_sel = 2'b00;
  logic          sample_tick;
  logic          bit_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  uart_frac_brg #(.MANT_W(MW)) u_uart_frac_brg (
    .clk(clk), .rst(rst), .en(en), .frac_style(frac_style),
    .div_mant(div_mant), .div_frac(div_frac), .os_sel(os_sel),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ratio_of(input int code);
    case (code)
      1: return 8;
      2: return 32;
      3: return 64;
      default: return 16;
    endcase
  endfunction

  // run from enable until the second bit tick and check all spacing rules
  task automatic measure(input bit style, input int mant, input int frac, input int code);
    int r, base, fe, t, last, nsamp, nbit, lim, bad_iv, bad_lock;
    string tag;
    r    = ratio_of(code);
    base = style ? ((mant == 0) ? 1 : mant) : mant + 1;
    fe   = style ? frac : 0;
    tag  = style ? ((mant == 0) ? "R3" : "R2") : "R1";
    @(negedge clk);
    en = 1'b0; frac_style = style; div_mant = MW'(mant);
    div_frac = 4'(frac); os_sel = 2'(code);
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    t = 0; last = 0; nsamp = 0; nbit = 0; bad_iv = 0; bad_lock = 0;
    lim = 2 * r * (base + 1) + 20;
    while (nbit < 2 && t < lim) begin
      @(negedge clk);
      t++;
      if (bit_tick && !sample_tick) bad_lock++;
      if (sample_tick) begin
        nsamp++;
        if (nsamp == 1)
          chk(t == base, "R7 first sample latency", t, base);
        else if (!((t - last == base) || (fe != 0 && t - last == base + 1)))
          bad_iv++;
        if (nsamp == 16 && fe != 0)
          chk(t == 16 * base + fe, tag, t, 16 * base + fe);
        last = t;
      end
      if (bit_tick) begin
        nbit++;
        chk(nsamp == nbit * r, "R4 bit tick on sample k*R", nsamp, nbit * r);
        chk(t == nbit * r * base + (nbit * r * fe) / 16, tag, t,
            nbit * r * base + (nbit * r * fe) / 16);
      end
    end
    chk(bad_iv == 0, tag, bad_iv, 0);
    chk(bad_lock == 0, "R4 bit without sample", bad_lock, 0);
    chk(nbit == 2, "R4 bit ticks seen", nbit, 2);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int t, first, second, bad, quiet;
    // R8: reset with enable high
    en = 1'b1; div_mant = 12'd2;
    repeat (5) begin
      @(negedge clk);
      chk(!sample_tick && !bit_tick, "R8 outputs in reset", int'(sample_tick) + int'(bit_tick), 0);
    end
    rst = 1'b0;
    en = 1'b0;

    // sweep: integer style (fraction must be ignored) and fractional style
    for (int code = 0; code < 4; code++) begin
      for (int m = 0; m < 5; m++)
        for (int fi = 0; fi < 4; fi++) begin
          int f;
          f = (fi == 0) ? 0 : (fi == 1) ? 1 : (fi == 2) ? 7 : 15;
          measure(1'b1, m, f, code);
        end
      measure(1'b0, 0, 9, code);
      measure(1'b0, 1, 15, code);
      measure(1'b0, 4, 3, code);
    end

    // R5: 16 MHz, divisor 103, x16
    measure(1'b0, 103, 0, 0);
    chk(16 * 104 == 1664, "R5 bit period", 16 * 104, 1664);

    // R6: change settings mid bit period
    @(negedge clk);
    en = 1'b0; frac_style = 1'b0; div_mant = 12'd3; div_frac = 4'd0; os_sel = 2'b00;
    @(negedge clk);
    en = 1'b1;
    t = 0; first = 0; second = 0; bad = 0;
    begin
      int last;
      last = 0;
      while (second == 0 && t < 400) begin
        @(negedge clk);
        t++;
        if (t == 20) begin div_mant = 12'd7; os_sel = 2'b01; div_frac = 4'd5; end
        if (sample_tick) begin
          if (first == 0 && t - last != 4) bad++;
          if (first != 0 && t - last != 8) bad++;
          last = t;
        end
        if (bit_tick) begin
          if (first == 0) first = t; else second = t;
        end
      end
    end
    chk(first == 64, "R6 old bit period kept", first, 64);
    chk(second == 128, "R6 new settings after bit tick", second, 128);
    chk(bad == 0, "R6 sample spacing", bad, 0);

    // R7: disable mid-run, stay silent, restart with new period
    @(negedge clk);
    en = 1'b0; div_mant = 12'd2; os_sel = 2'b01;
    @(negedge clk);
    en = 1'b1;
    repeat (30) @(negedge clk);
    en = 1'b0;
    quiet = 0;
    repeat (40) begin
      @(negedge clk);
      if (sample_tick || bit_tick) quiet++;
    end
    chk(quiet == 0, "R7 no ticks while disabled", quiet, 0);
    div_mant = 12'd5;
    @(negedge clk);
    en = 1'b1;
    t = 0; first = 0;
    while (first == 0 && t < 50) begin
      @(negedge clk);
      t++;
      if (sample_tick) first = t;
    end
    chk(first == 6, "R7 first tick after re-enable", first, 6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule